// File: doc/BRIEF.md
# CAN Receive Frame Checker

This block sits behind a bit-timing unit and receives one sampled bus level per bit-time strobe (1 = recessive, 0 = dominant). It waits for a dominant start bit, strips stuff bits, and splits the stream into an 11-bit identifier, the remote-request flag, two reserved bits, a 4-bit length code, up to eight data bytes and a 15-bit CRC sequence. Identifier, request flag, length code and data are held in output registers.

It keeps a running CRC over the unstuffed bits from the start bit through the data field, and also feeds in the received CRC sequence. A zero remainder means the CRC matches. On a match, with a recessive CRC delimiter, the block pulls the bus dominant for the one bit time of the acknowledge slot. It then checks the acknowledge delimiter and the seven end-of-frame bits. The result of each frame is a one-cycle pulse: a valid frame, a form error, a stuff error or a CRC error. After an error the block ignores the bus until it has seen seven recessive bits in a row, with destuffing off, and then waits for the next start bit.

Top module: `can_rx_frame_checker`

## Requirements
- R1: From the start bit through the last CRC bit, including one pending stuff bit after the final CRC bit, the bit that follows five equal bits is discarded, so field values are the unstuffed values.
- R2: A sixth equal bit where a stuff bit is expected gives a one-cycle `stuffErr` pulse, and no `frameValid` for that frame.
- R3: The identifier (11 bits), then the remote flag (1 = remote), then the length code (4 bits) are taken MSB first and appear on `rxId`, `rxRtr` and `rxDlc` when `frameValid` pulses.
- R4: The number of stored bytes is 0 for a remote frame and min(length code, 8) otherwise. Byte k lands in `rxData[8k+7:8k]`, and the first bit received for a byte goes to bit 7. Bytes beyond that count read zero because the buffer is cleared at every start bit.
- R5: The CRC uses the polynomial 0x4599 with an all-zero start value. On a mismatch, `crcErr` pulses in the cycle after the acknowledge-delimiter strobe, no acknowledge is driven and `frameValid` stays low.
- R6: On a CRC match with a recessive CRC delimiter, `ackDominant` rises in the cycle after the CRC-delimiter strobe and falls in the cycle after the next strobe. It is low at all other times.
- R7: A recessive reserved bit, or a dominant bit in the CRC delimiter, the acknowledge delimiter or any end-of-frame bit, gives a one-cycle `formErr` pulse and no `frameValid`.
- R8: `frameValid` pulses for one cycle, in the cycle after the seventh end-of-frame strobe, only for a frame with no error. At most one of the four outcome pulses is high in any cycle.
- R9: After any error, the next start bit is accepted only after seven consecutive recessive bits, and the following error-free frame is received normally.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitStrobe | input | 1 | One-cycle pulse marking a sampled bit |
| rxBit | input | 1 | Sampled bus level, 1 = recessive |
| ackDominant | output | 1 | Drive the bus dominant while high |
| frameValid | output | 1 | Pulse: error-free frame completed |
| formErr | output | 1 | Pulse: fixed-form bit violated |
| stuffErr | output | 1 | Pulse: stuffing rule violated |
| crcErr | output | 1 | Pulse: CRC mismatch |
| rxId | output | 11 | Received identifier |
| rxRtr | output | 1 | Received remote flag |
| rxDlc | output | 4 | Received length code, as sent |
| rxData | output | 64 | Data buffer, byte 0 in bits 7:0 |

## Verification
At the CRC-delimiter strobe, two decisions fall in the same cycle: whether to acknowledge (the CRC result) and whether the delimiter has the right form. The bench sends a frame with a correct CRC but a dominant delimiter. It expects a form error and a recessive acknowledge slot, which shows that the form check wins over the CRC result. The same cycle also has to handle a stuff bit still pending after the last CRC bit. Frames whose CRC ends in five equal bits test this: random frames, plus all-zero and all-one frames, where the bench expects the stuff bit to be dropped before the delimiter check.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int ID_W      = 11;
  localparam int DLC_W     = 4;
  localparam int CRC_W     = 15;
  localparam int MAX_BYTES = 8;
  localparam int EOF_LEN   = 7;
  localparam int STUFF_RUN = 5;
  localparam int RSV_BITS  = 2;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
  localparam int DATA_W    = MAX_BYTES * 8;
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int CNT_W     = IDX_W + 1;
  localparam int CTRL_LEN  = RSV_BITS + DLC_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARB, ST_CTRL, ST_DATA, ST_CRC,
    ST_CRCDEL, ST_ACKSLOT, ST_ACKDEL, ST_EOF, ST_SEEK
  } rxState_t;

  typedef struct packed {
    logic             sof;
    logic             shift;
    logic             capArb;
    logic             capCtrl;
    logic             dataWr;
    logic [IDX_W-1:0] dataIdx;
  } dpCtl_t;
endpackage

// File: rtl/can_rx_dpath.sv
module can_rx_dpath
  import can_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxBit,
  input  dpCtl_t             ctl,
  output logic [ID_W-1:0]    rxId,
  output logic               rxRtr,
  output logic [DLC_W-1:0]   rxDlc,
  output logic [DATA_W-1:0]  rxData,
  output logic [DLC_W-2:0]   dlcHead,
  output logic               crcZero
);
  logic [CRC_W-1:0] crcQ;
  logic [ID_W-1:0]  fieldSr;
  logic             feedBack;

  assign feedBack = rxBit ^ crcQ[CRC_W-1];
  assign dlcHead  = fieldSr[DLC_W-2:0];
  assign crcZero  = (crcQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ    <= '0;
      fieldSr <= '0;
      rxId    <= '0;
      rxRtr   <= 1'b0;
      rxDlc   <= '0;
      rxData  <= '0;
    end else begin
      if (ctl.sof) begin
        crcQ    <= '0;
        fieldSr <= '0;
        rxData  <= '0;
      end else if (ctl.shift) begin
        crcQ    <= {crcQ[CRC_W-2:0], 1'b0} ^ (feedBack ? CRC_POLY : '0);
        fieldSr <= {fieldSr[ID_W-2:0], rxBit};
      end
      if (ctl.capArb) begin
        rxId  <= fieldSr;
        rxRtr <= rxBit;
      end
      if (ctl.capCtrl) rxDlc <= {fieldSr[DLC_W-2:0], rxBit};
      if (ctl.dataWr)  rxData[ctl.dataIdx] <= rxBit;
    end
  end
endmodule

// File: rtl/can_rx_ctrl.sv
module can_rx_ctrl
  import can_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStrobe,
  input  logic             rxBit,
  input  logic             rxRtr,
  input  logic [DLC_W-2:0] dlcHead,
  input  logic             crcZero,
  output dpCtl_t           ctl,
  output rxState_t         curState,
  output logic             ackDominant,
  output logic             frameValid,
  output logic             formErr,
  output logic             stuffErr,
  output logic             crcErr
);
  rxState_t         stQ, stD;
  logic [CNT_W-1:0] cntQ, cntD, lastDataCnt;
  logic [2:0]       runQ, runD;
  logic             lastQ, lastD;
  logic [DLC_W-1:0] nbQ, nbD, dlcNow, nbNow;
  logic             ackQ, ackD, validD, formD, stuffD, crcD;
  logic             inZone, isStuff;

  assign dlcNow      = {dlcHead, rxBit};
  assign nbNow       = rxRtr ? '0 :
                       (dlcNow > DLC_W'(MAX_BYTES) ? DLC_W'(MAX_BYTES) : dlcNow);
  assign lastDataCnt = CNT_W'({nbQ, 3'b000}) - CNT_W'(1);
  assign inZone      = stQ inside {ST_ARB, ST_CTRL, ST_DATA, ST_CRC, ST_CRCDEL};
  assign isStuff     = inZone && (runQ == 3'(STUFF_RUN));

  always_comb begin
    stD = stQ; cntD = cntQ; runD = runQ; lastD = lastQ; nbD = nbQ; ackD = ackQ;
    validD = 1'b0; formD = 1'b0; stuffD = 1'b0; crcD = 1'b0;
    ctl = '0;
    if (bitStrobe) begin
      ackD = 1'b0;
      if (inZone) begin
        runD  = (rxBit == lastQ) ? runQ + 3'd1 : 3'd1;
        lastD = rxBit;
      end
      if (isStuff) begin
        runD = 3'd1;
        if (rxBit == lastQ) begin
          stuffD = 1'b1; stD = ST_SEEK; cntD = '0;
        end
      end else begin
        case (stQ)
          ST_IDLE: if (!rxBit) begin
            ctl.sof = 1'b1; stD = ST_ARB; cntD = '0; runD = 3'd1; lastD = 1'b0;
          end
          ST_ARB: begin
            ctl.shift = 1'b1;
            if (cntQ == CNT_W'(ID_W)) begin
              ctl.capArb = 1'b1; stD = ST_CTRL; cntD = '0;
            end else cntD = cntQ + CNT_W'(1);
          end
          ST_CTRL: begin
            ctl.shift = 1'b1;
            if (cntQ < CNT_W'(RSV_BITS) && rxBit) begin
              formD = 1'b1; stD = ST_SEEK; cntD = '0;
            end else if (cntQ == CNT_W'(CTRL_LEN - 1)) begin
              ctl.capCtrl = 1'b1; nbD = nbNow; cntD = '0;
              stD = (nbNow == '0) ? ST_CRC : ST_DATA;
            end else cntD = cntQ + CNT_W'(1);
          end
          ST_DATA: begin
            ctl.shift   = 1'b1;
            ctl.dataWr  = 1'b1;
            ctl.dataIdx = {cntQ[IDX_W-1:3], ~cntQ[2:0]};
            if (cntQ == lastDataCnt) begin
              stD = ST_CRC; cntD = '0;
            end else cntD = cntQ + CNT_W'(1);
          end
          ST_CRC: begin
            ctl.shift = 1'b1;
            if (cntQ == CNT_W'(CRC_W - 1)) stD = ST_CRCDEL;
            else cntD = cntQ + CNT_W'(1);
          end
          ST_CRCDEL: if (!rxBit) begin
            formD = 1'b1; stD = ST_SEEK; cntD = '0;
          end else begin
            ackD = crcZero; stD = ST_ACKSLOT;
          end
          ST_ACKSLOT: stD = ST_ACKDEL;
          ST_ACKDEL: begin
            cntD = '0;
            if (!rxBit) begin
              formD = 1'b1; stD = ST_SEEK;
            end else if (!crcZero) begin
              crcD = 1'b1; stD = ST_SEEK;
            end else stD = ST_EOF;
          end
          ST_EOF: if (!rxBit) begin
            formD = 1'b1; stD = ST_SEEK; cntD = '0;
          end else if (cntQ == CNT_W'(EOF_LEN - 1)) begin
            validD = 1'b1; stD = ST_IDLE;
          end else cntD = cntQ + CNT_W'(1);
          ST_SEEK: if (!rxBit) cntD = '0;
            else if (cntQ == CNT_W'(EOF_LEN - 1)) stD = ST_IDLE;
            else cntD = cntQ + CNT_W'(1);
          default: stD = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ <= ST_IDLE; cntQ <= '0; runQ <= '0; lastQ <= 1'b1; nbQ <= '0;
      ackQ <= 1'b0; frameValid <= 1'b0; formErr <= 1'b0;
      stuffErr <= 1'b0; crcErr <= 1'b0;
    end else begin
      stQ <= stD; cntQ <= cntD; runQ <= runD; lastQ <= lastD; nbQ <= nbD;
      ackQ <= ackD; frameValid <= validD; formErr <= formD;
      stuffErr <= stuffD; crcErr <= crcD;
    end
  end

  assign curState    = stQ;
  assign ackDominant = ackQ;
endmodule

// File: rtl/can_rx_frame_checker.sv
module can_rx_frame_checker
  import can_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStrobe,
  input  logic              rxBit,
  output logic              ackDominant,
  output logic              frameValid,
  output logic              formErr,
  output logic              stuffErr,
  output logic              crcErr,
  output logic [ID_W-1:0]   rxId,
  output logic              rxRtr,
  output logic [DLC_W-1:0]  rxDlc,
  output logic [DATA_W-1:0] rxData
);
  dpCtl_t           ctl;
  rxState_t         curState;
  logic [DLC_W-2:0] dlcHead;
  logic             crcZero;

  can_rx_ctrl u_ctrl (
    .clk, .rstN, .bitStrobe, .rxBit, .rxRtr, .dlcHead, .crcZero,
    .ctl, .curState, .ackDominant, .frameValid, .formErr, .stuffErr, .crcErr
  );

  can_rx_dpath u_dpath (
    .clk, .rstN, .rxBit, .ctl, .rxId, .rxRtr, .rxDlc, .rxData, .dlcHead, .crcZero
  );
endmodule

// File: rtl/can_rx_checker.sv
module can_rx_checker
  import can_rx_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     bitStrobe,
  input logic     rxBit,
  input logic     ackDominant,
  input logic     frameValid,
  input logic     formErr,
  input logic     stuffErr,
  input logic     crcErr,
  input rxState_t curState
);
  AST_ACK_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (ackDominant && bitStrobe) |=> !ackDominant); // R6
  AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    ackDominant |-> (curState == ST_ACKSLOT)); // R6
  AST_ACK_AFTER_DELIM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDominant) |-> $past(bitStrobe && rxBit)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameValid, formErr, stuffErr, crcErr})); // R8
  AST_ERR_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (formErr || stuffErr || crcErr) |-> $past(bitStrobe)); // R7
  AST_CRC_ERR_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> !ackDominant); // R5
endmodule

bind can_rx_frame_checker can_rx_checker u_chk (
  .clk, .rstN, .bitStrobe, .rxBit, .ackDominant, .frameValid,
  .formErr, .stuffErr, .crcErr, .curState
);

// File: tb/test_can_rx_frame_checker.sv
`timescale 1ns/1ps
module test_can_rx_frame_checker;
  localparam int M_OK = 0, M_CRC = 1, M_STUFF = 2, M_RESV = 3,
                 M_CRCDEL = 4, M_ACKDEL = 5, M_EOF = 6;

  logic clk = 1'b0, rstN = 1'b0, bitStrobe = 1'b0, txBit = 1'b1, lastBus;
  logic busBit, ackDominant, frameValid, formErr, stuffErr, crcErr, rxRtr;
  logic [10:0] rxId;
  logic [3:0]  rxDlc;
  logic [63:0] rxData;
  int checkCnt = 0, failCnt = 0;
  int vCnt, fCnt, sCnt, cCnt;
  logic uBits [256];
  logic sBits [512];
  int uLen, sLen;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign busBit = txBit & ~ackDominant;

  can_rx_frame_checker i_can_rx_frame_checker (
    .clk, .rstN, .bitStrobe, .rxBit(busBit), .ackDominant, .frameValid,
    .formErr, .stuffErr, .crcErr, .rxId, .rxRtr, .rxDlc, .rxData
  );

  always @(negedge clk) if (rstN) begin
    if (frameValid) vCnt++;
    if (formErr)    fCnt++;
    if (stuffErr)   sCnt++;
    if (crcErr)     cCnt++;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic endTest();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  function automatic logic [14:0] calcCrc(input int n);
    logic [14:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic fb = uBits[i] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    return c;
  endfunction

  task automatic pushU(input logic b); uBits[uLen] = b; uLen++; endtask
  task automatic pushS(input logic b); sBits[sLen] = b; sLen++; endtask

  task automatic sendBit(input logic b);
    @(negedge clk); txBit = b; bitStrobe = 1'b1; #1 lastBus = busBit;
    @(negedge clk); bitStrobe = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic runFrame(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                          input logic [63:0] data, input int mode, input string tag);
    int nb, run, ackIdx;
    logic lastB, ackSeen;
    logic [14:0] crc;
    logic [63:0] expData;
    bit injected;
    nb = rtr ? 0 : (dlc > 8 ? 8 : int'(dlc));
    uLen = 0; sLen = 0;
    pushU(1'b0);
    for (int i = 10; i >= 0; i--) pushU(id[i]);
    pushU(rtr);
    pushU(1'b0);
    pushU(mode == M_RESV);
    for (int i = 3; i >= 0; i--) pushU(dlc[i]);
    for (int k = 0; k < nb; k++)
      for (int i = 7; i >= 0; i--) pushU(data[8*k+i]);
    crc = calcCrc(uLen);
    if (mode == M_CRC) crc[0] = ~crc[0];
    for (int i = 14; i >= 0; i--) pushU(crc[i]);
    run = 0; lastB = 1'b1; injected = 0;
    for (int i = 0; i < uLen; i++) begin
      pushS(uBits[i]);
      run = (uBits[i] == lastB) ? run + 1 : 1;
      lastB = uBits[i];
      if (run == 5) begin
        if (mode == M_STUFF && !injected) begin pushS(lastB); injected = 1; end
        else begin pushS(~lastB); lastB = ~lastB; end
        run = 1;
      end
    end
    pushS(mode != M_CRCDEL);
    ackIdx = sLen; pushS(1'b1);
    pushS(mode != M_ACKDEL);
    for (int k = 0; k < 7; k++) pushS(!(mode == M_EOF && k == 3));
    for (int k = 0; k < 8; k++) pushS(1'b1);
    vCnt = 0; fCnt = 0; sCnt = 0; cCnt = 0; ackSeen = 1'b0;
    for (int i = 0; i < sLen; i++) begin
      sendBit(sBits[i]);
      if (i == ackIdx) ackSeen = ~lastBus;
    end
    expData = '0;
    for (int k = 0; k < nb; k++) expData[8*k +: 8] = data[8*k +: 8];
    case (mode)
      M_OK: begin
        check({tag, " R8 frameValid count"}, 64'(vCnt), 64'd1);
        check({tag, " R7 no error pulses"}, 64'(fCnt + sCnt + cCnt), 64'd0);
        check({tag, " R6 acknowledge slot dominant"}, 64'(ackSeen), 64'd1);
        check({tag, " R3 identifier"}, 64'(rxId), 64'(id));
        check({tag, " R3 remote flag"}, 64'(rxRtr), 64'(rtr));
        check({tag, " R3 length code"}, 64'(rxDlc), 64'(dlc));
        check({tag, " R4 data buffer"}, rxData, expData);
      end
      M_CRC: begin
        check({tag, " R5 crcErr count"}, 64'(cCnt), 64'd1);
        check({tag, " R5 no acknowledge"}, 64'(ackSeen), 64'd0);
        check({tag, " R5 no frameValid"}, 64'(vCnt), 64'd0);
      end
      M_STUFF: begin
        check({tag, " R2 stuffErr count"}, 64'(sCnt), 64'd1);
        check({tag, " R2 no frameValid"}, 64'(vCnt), 64'd0);
      end
      default: begin
        check({tag, " R7 formErr count"}, 64'(fCnt), 64'd1);
        check({tag, " R7 no frameValid"}, 64'(vCnt), 64'd0);
        check({tag, " R6 acknowledge per CRC"}, 64'(ackSeen),
              64'(mode == M_ACKDEL || mode == M_EOF));
      end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    endTest();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset outputs",
          {ackDominant, frameValid, formErr, stuffErr, crcErr, rxRtr, rxDlc, rxId},
          64'd0);
    check("R10 reset data", rxData, 64'd0);
    runFrame(11'h000, 1'b0, 4'd8, 64'h0, M_OK, "R1 all-zero stuffing");
    runFrame(11'h7FF, 1'b0, 4'd8, {64{1'b1}}, M_OK, "R1 all-one stuffing");
    runFrame(11'h123, 1'b0, 4'd2, 64'h0123_4567_89AB_CDEF, M_OK, "R4 short after long");
    runFrame(11'h456, 1'b0, 4'd0, 64'hDEAD_BEEF_0000_1111, M_OK, "R4 zero length");
    runFrame(11'h2A5, 1'b0, 4'd15, 64'h8877_6655_4433_2211, M_OK, "R4 length above 8");
    runFrame(11'h3C3, 1'b1, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, M_OK, "R4 remote no data");
    runFrame(11'h155, 1'b0, 4'd3, 64'h00A5_5A3C, M_CRC, "R5 crc flip");
    runFrame(11'h000, 1'b0, 4'd1, 64'h7E, M_STUFF, "R2 six equal");
    runFrame(11'h0F0, 1'b0, 4'd4, 64'h1234_5678, M_OK, "R9 after stuff error");
    runFrame(11'h321, 1'b0, 4'd1, 64'h55, M_RESV, "R7 reserved recessive");
    runFrame(11'h321, 1'b0, 4'd1, 64'h55, M_CRCDEL, "R7 crc delimiter");
    runFrame(11'h321, 1'b0, 4'd1, 64'h55, M_ACKDEL, "R7 ack delimiter");
    runFrame(11'h321, 1'b0, 4'd1, 64'h55, M_EOF, "R7 end of frame");
    runFrame(11'h6B1, 1'b0, 4'd6, 64'hCAFE_F00D_B00C, M_OK, "R9 after form error");
    for (int n = 0; n < 60; n++) begin
      logic [10:0] rid = 11'($urandom);
      logic        rr  = ($urandom % 4) == 0;
      logic [3:0]  rd  = 4'($urandom);
      logic [63:0] dat = {$urandom, $urandom};
      runFrame(rid, rr, rd, dat, M_OK, "R1 R3 random");
    end
    endTest();
  end
endmodule